// File: doc/BRIEF.md
# Stale Victim Buffer with Age Limit

This block is a small, fully associative side store that sits next to a private L1 data cache. When the L1 evicts a line that coherence had already invalidated, the line is copied here. The copy keeps the value the line held when it was invalidated. When a later load misses in the L1 because of that invalidation, the buffer can answer with the old copy. The load then completes with slightly out-of-date data instead of waiting for a refetch.

Each entry carries an age counter that advances on a tick-enable input. An entry is dropped once its age reaches a configurable limit, which puts a bound on how old a served value can be. A store miss to a held line removes that line. A single flush input empties the whole buffer in one cycle.

Top module: `stale_victim_buf`

## Requirements
- R1: The buffer holds 8 entries. Eight inserts of distinct tags are all held and can be found by later lookups.
- R2: An insert is captured only when `evict_inval` is 1. An eviction with `evict_inval` = 0 leaves the buffer unchanged.
- R3: A lookup hit returns exactly the data word that was stored with that tag. Nothing else changes the stored word except a later insert of the same tag.
- R4: Every lookup request gets `rsp_valid` = 1 in the next cycle. `rsp_hit` = 1 only when `lk_coh` = 1 and a valid entry holds the tag. `rsp_data` is zero whenever `rsp_hit` = 0.
- R5: On each cycle with `age_tick` = 1, every valid entry's age rises by one, starting from 0 at insert. The entry is removed in the same cycle its age reaches TIMEOUT. It therefore hits for TIMEOUT ticked cycles after the insert and misses after that. Without ticks it does not age.
- R6: An insert of a new tag goes to the lowest-index empty entry. If all entries are valid, it replaces the entry with the largest age, and ties go to the lowest index. Entries fill in index order.
- R7: An insert whose tag is already held overwrites that entry's data and sets its age back to zero.
- R8: A store miss (`st_valid`) whose tag matches a held entry removes that entry.
- R9: A lookup made in the same cycle as an insert of the same tag returns the contents from before the insert.
- R10: `flush_all` makes every entry invalid in one cycle. It takes priority over an insert in the same cycle.
- R11: After reset, every entry is invalid.
- R12: An insert and a store miss to the same tag in the same cycle leave that tag absent from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| age_tick | input | 1 | Advances every entry's age by one |
| flush_all | input | 1 | Invalidates all entries |
| evict_valid | input | 1 | L1 eviction present |
| evict_inval | input | 1 | Evicted line was in the coherence-invalidated state |
| evict_tag | input | TAG_W | Line address tag of the eviction |
| evict_data | input | DATA_W | Line data as of its invalidation |
| lk_valid | input | 1 | Load-miss lookup request |
| lk_coh | input | 1 | Miss was caused by a coherence invalidation |
| lk_tag | input | TAG_W | Lookup tag |
| st_valid | input | 1 | Store miss present |
| st_tag | input | TAG_W | Store miss tag |
| rsp_valid | output | 1 | Registered lookup response present |
| rsp_hit | output | 1 | Stale copy found |
| rsp_data | output | DATA_W | Stale data, zero on miss |

## Verification
The hardest state to reach is a full buffer whose entries have distinct ages, because replacement by age only matters then. Another hard case is an entry sitting exactly one tick before its limit. The bench gets to both by inserting eight tags on consecutive ticked cycles, and by counting exact tick runs after an insert. It then checks which tag survives the next insert, and the cycle in which a held line stops hitting. A long mixed sweep uses a small set of tags so that tag collisions, re-inserts, store-miss removals, flushes and timeouts happen often and in overlapping cycles. A cycle model built from the requirements predicts every response.

// File: rtl/svb_pkg.sv
// Shared types for the stale victim buffer.
package svb_pkg;
    // Per-entry update command chosen by the top each cycle.
    typedef enum logic [1:0] {
        OP_KEEP  = 2'd0,   // hold, age on tick
        OP_FILL  = 2'd1,   // write new line, age to zero
        OP_DROP  = 2'd2,   // removed by a matching store miss
        OP_CLEAR = 2'd3    // flush
    } ent_op_e;
endpackage

// File: rtl/svb_entry.sv
// One buffer entry: valid bit, tag, data word and age counter.
// Assumes TIMEOUT fits in AGE_W bits. The entry clears itself on the tick
// where its age reaches TIMEOUT.
module svb_entry
    import svb_pkg::*;
#(
    parameter int TAG_W   = 26,
    parameter int DATA_W  = 64,
    parameter int AGE_W   = 8,
    parameter int TIMEOUT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ent_op_e           op,
    input  logic              tick,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              vld,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] data,
    output logic [AGE_W-1:0]  age
);
    localparam logic [AGE_W-1:0] LIMIT = AGE_W'(TIMEOUT);

    logic [AGE_W-1:0] age_inc;

    // Next age value on a tick.
    always_comb age_inc = age + AGE_W'(1);

    // Entry state update by command, with ageing while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            tag  <= '0;
            data <= '0;
            age  <= '0;
        end else begin
            case (op)
                OP_CLEAR, OP_DROP: vld <= 1'b0;
                OP_FILL: begin
                    vld  <= 1'b1;
                    tag  <= fill_tag;
                    data <= fill_data;
                    age  <= '0;
                end
                default: begin
                    if (vld && tick) begin
                        age <= age_inc;
                        if (age_inc == LIMIT) vld <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R5: a held entry never shows an age at or past the limit.
    a_r5_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (age < LIMIT));

    // R7: a fill always leaves a fresh valid entry.
    a_r7_fill_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL) |=> (vld && age == '0));
endmodule

// File: rtl/svb_victim_sel.sv
// Picks the entry an insert writes. A matching tag is picked first, then the
// lowest-index empty entry, then the oldest entry (lowest index on ties).
// Assumes at most one bit of 'match' is set.
module svb_victim_sel #(
    parameter int N     = 8,
    parameter int AGE_W = 8
) (
    input  logic [N-1:0]       vld,
    input  logic [N-1:0]       match,
    input  logic [N*AGE_W-1:0] ages,
    output logic [N-1:0]       sel
);
    // Priority selection across the three rules.
    always_comb begin
        logic             found;
        int               best;
        logic [AGE_W-1:0] best_age;
        sel      = '0;
        found    = 1'b0;
        best     = 0;
        best_age = ages[0 +: AGE_W];
        for (int i = 0; i < N; i++) begin
            if (match[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!vld[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        for (int i = 1; i < N; i++) begin
            if (ages[i*AGE_W +: AGE_W] > best_age) begin
                best     = i;
                best_age = ages[i*AGE_W +: AGE_W];
            end
        end
        if (!found) sel[best] = 1'b1;
    end
endmodule

// File: rtl/svb_lookup.sv
// Compares a tag against all entries in parallel and gives back the hit and
// the matching data as an AND-OR mux. Assumes valid tags are unique.
module svb_lookup #(
    parameter int N      = 8,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 64
) (
    input  logic [N-1:0]        vld,
    input  logic [N*TAG_W-1:0]  tags,
    input  logic [N*DATA_W-1:0] datas,
    input  logic [TAG_W-1:0]    key,
    output logic [N-1:0]        match,
    output logic                hit,
    output logic [DATA_W-1:0]   data
);
    // Per-entry comparators.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
    end

    // Reduction of the matches into hit and data.
    always_comb begin
        hit  = |match;
        data = '0;
        for (int i = 0; i < N; i++)
            data = data | (datas[i*DATA_W +: DATA_W] & {DATA_W{match[i]}});
    end
endmodule

// File: rtl/stale_victim_buf.sv
// Stale victim buffer top. It captures L1 evictions of coherence-invalidated
// lines, serves them to coherence load misses with a one-cycle registered
// response, and ages the entries out. Assumes tags in valid entries stay
// unique, which the insert rules keep true.
module stale_victim_buf
    import svb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int TAG_W       = 26,
    parameter int DATA_W      = 64,
    parameter int AGE_W       = 8,
    parameter int TIMEOUT     = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              age_tick,
    input  logic              flush_all,
    input  logic              evict_valid,
    input  logic              evict_inval,
    input  logic [TAG_W-1:0]  evict_tag,
    input  logic [DATA_W-1:0] evict_data,
    input  logic              lk_valid,
    input  logic              lk_coh,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int N = NUM_ENTRIES;

    logic [N-1:0]        vld;
    logic [N*TAG_W-1:0]  tags;
    logic [N*DATA_W-1:0] datas;
    logic [N*AGE_W-1:0]  ages;
    logic [N-1:0]        ins_match, lk_match, st_match, sel;
    logic                ins_hit_unused, st_hit_unused, lk_hit;
    logic [DATA_W-1:0]   ins_data_unused, st_data_unused, lk_data;
    logic                ins_take;

    // Tag match for an insert, to find an existing copy.
    svb_lookup #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ins_cmp (
        .vld(vld), .tags(tags), .datas(datas), .key(evict_tag),
        .match(ins_match), .hit(ins_hit_unused), .data(ins_data_unused));

    // Tag match for a store miss, to remove a held copy.
    svb_lookup #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_st_cmp (
        .vld(vld), .tags(tags), .datas(datas), .key(st_tag),
        .match(st_match), .hit(st_hit_unused), .data(st_data_unused));

    // Load lookup port.
    svb_lookup #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lk_cmp (
        .vld(vld), .tags(tags), .datas(datas), .key(lk_tag),
        .match(lk_match), .hit(lk_hit), .data(lk_data));

    // Choice of the entry to write.
    svb_victim_sel #(.N(N), .AGE_W(AGE_W)) u_sel (
        .vld(vld), .match(ins_match), .ages(ages), .sel(sel));

    // An insert counts only for invalidated lines that no store miss in the same cycle cancels.
    always_comb ins_take = evict_valid && evict_inval &&
                           !(st_valid && (st_tag == evict_tag));

    for (genvar g = 0; g < N; g++) begin : g_ent
        ent_op_e op;

        // Command for this entry; flush, fill and store drop in that order.
        always_comb begin
            if (flush_all)                 op = OP_CLEAR;
            else if (ins_take && sel[g])   op = OP_FILL;
            else if (st_valid && st_match[g]) op = OP_DROP;
            else                           op = OP_KEEP;
        end

        svb_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .AGE_W(AGE_W),
                    .TIMEOUT(TIMEOUT)) u_ent (
            .clk(clk), .rst_n(rst_n), .op(op), .tick(age_tick),
            .fill_tag(evict_tag), .fill_data(evict_data),
            .vld(vld[g]),
            .tag(tags[g*TAG_W +: TAG_W]),
            .data(datas[g*DATA_W +: DATA_W]),
            .age(ages[g*AGE_W +: AGE_W]));
    end

    // Registered lookup response, taken from state before this cycle's updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_coh && lk_hit;
            rsp_data  <= (lk_valid && lk_coh && lk_hit) ? lk_data : '0;
        end
    end

    // R1: held tags are unique, so at most one entry answers.
    a_r1_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R6: an accepted insert writes exactly one entry.
    a_r6_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
        ins_take |-> $onehot(sel));

    // R4: a response follows each request one cycle later.
    a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R4: no hit without a coherence lookup.
    a_r4_hit_needs_coh: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_coh) |=> !rsp_hit);

    // R10: flush empties every entry.
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld == '0));
endmodule

// File: tb/tb_stale_victim_buf.sv
module tb_stale_victim_buf;
    localparam int N  = 8;
    localparam int TW = 6;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int TO = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic age_tick = 0, flush_all = 0, evict_valid = 0, evict_inval = 0;
    logic [TW-1:0] evict_tag = '0, lk_tag = '0, st_tag = '0;
    logic [DW-1:0] evict_data = '0;
    logic lk_valid = 0, lk_coh = 0, st_valid = 0;
    logic rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_data;

    int total = 0;
    int bad = 0;

    // Reference model state.
    bit            m_v [N];
    logic [TW-1:0] m_t [N];
    logic [DW-1:0] m_d [N];
    int            m_a [N];

    always #5 clk = ~clk;

    stale_victim_buf #(.NUM_ENTRIES(N), .TAG_W(TW), .DATA_W(DW),
                       .AGE_W(AW), .TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n), .age_tick(age_tick), .flush_all(flush_all),
        .evict_valid(evict_valid), .evict_inval(evict_inval),
        .evict_tag(evict_tag), .evict_data(evict_data),
        .lk_valid(lk_valid), .lk_coh(lk_coh), .lk_tag(lk_tag),
        .st_valid(st_valid), .st_tag(st_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive, predict from the model, clock, update the model, check.
    task automatic step(input bit iv, input bit ii, input logic [TW-1:0] it,
                        input logic [DW-1:0] id, input bit lv, input bit lc,
                        input logic [TW-1:0] lt, input bit sv,
                        input logic [TW-1:0] stt, input bit fl, input bit tk,
                        input string req, output bit gh, output logic [DW-1:0] gd);
        bit e_hit;
        logic [DW-1:0] e_dat;
        bit take;
        int vic;
        @(negedge clk);
        evict_valid = iv; evict_inval = ii; evict_tag = it; evict_data = id;
        lk_valid = lv; lk_coh = lc; lk_tag = lt; st_valid = sv; st_tag = stt;
        flush_all = fl; age_tick = tk;
        e_hit = 0; e_dat = '0;
        for (int i = 0; i < N; i++)
            if (lv && lc && m_v[i] && m_t[i] == lt) begin e_hit = 1; e_dat = m_d[i]; end
        take = iv && ii && !(sv && stt == it);
        vic = -1;
        for (int i = 0; i < N; i++) if (vic < 0 && m_v[i] && m_t[i] == it) vic = i;
        for (int i = 0; i < N; i++) if (vic < 0 && !m_v[i]) vic = i;
        if (vic < 0) begin
            vic = 0;
            for (int i = 1; i < N; i++) if (m_a[i] > m_a[vic]) vic = i;
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (fl) m_v[i] = 0;
            else if (take && i == vic) begin
                m_v[i] = 1; m_t[i] = it; m_d[i] = id; m_a[i] = 0;
            end else if (sv && m_v[i] && m_t[i] == stt) m_v[i] = 0;
            else if (m_v[i] && tk) begin
                m_a[i]++;
                if (m_a[i] == TO) m_v[i] = 0;
            end
        end
        #1;
        gh = rsp_hit; gd = rsp_data;
        if (lv) begin
            chk({req, " R4 rsp_valid"}, 32'(rsp_valid), 32'd1);
            chk({req, " hit"}, 32'(rsp_hit), 32'(e_hit));
            chk({req, " data"}, 32'(rsp_data), 32'(e_dat));
        end
    endtask

    task automatic ins(input logic [TW-1:0] t, input logic [DW-1:0] d, input bit tk);
        bit h; logic [DW-1:0] x;
        step(1, 1, t, d, 0, 0, '0, 0, '0, 0, tk, "ins", h, x);
    endtask

    task automatic look(input logic [TW-1:0] t, input bit tk, input string req,
                        output bit h, output logic [DW-1:0] d);
        step(0, 0, '0, '0, 1, 1, t, 0, '0, 0, tk, req, h, d);
    endtask

    task automatic flush();
        bit h; logic [DW-1:0] x;
        step(0, 0, '0, '0, 0, 0, '0, 0, '0, 1, 0, "flush", h, x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit h;
        logic [DW-1:0] d;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = '0; m_d[i] = '0; m_a[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: empty after reset.
        look(6'd5, 0, "R11", h, d);
        chk("R11 literal miss", 32'(h), 32'd0);

        // R2: eviction of a valid line is not captured.
        step(1, 0, 6'd3, 16'h7777, 0, 0, '0, 0, '0, 0, 0, "R2", h, d);
        look(6'd3, 0, "R2", h, d);
        chk("R2 literal miss", 32'(h), 32'd0);

        // R3: stored word returned.
        ins(6'd3, 16'hA5A5, 0);
        look(6'd3, 0, "R3", h, d);
        chk("R3 literal data", 32'(d), 32'hA5A5);

        // R4: non-coherence lookup gets a response but no hit.
        step(0, 0, '0, '0, 1, 0, 6'd3, 0, '0, 0, 0, "R4", h, d);
        chk("R4 literal no hit", 32'(h), 32'd0);

        // R9 then R7: same-cycle insert returns old data, then new data.
        step(1, 1, 6'd3, 16'h1111, 1, 1, 6'd3, 0, '0, 0, 0, "R9", h, d);
        chk("R9 literal old data", 32'(d), 32'hA5A5);
        look(6'd3, 0, "R7", h, d);
        chk("R7 literal new data", 32'(d), 32'h1111);

        // R8: store miss removes.
        step(0, 0, '0, '0, 0, 0, '0, 1, 6'd3, 0, 0, "R8", h, d);
        look(6'd3, 0, "R8", h, d);
        chk("R8 literal miss", 32'(h), 32'd0);

        // R12: insert cancelled by same-cycle store miss.
        step(1, 1, 6'd4, 16'h4444, 0, 0, '0, 1, 6'd4, 0, 0, "R12", h, d);
        look(6'd4, 0, "R12", h, d);
        chk("R12 literal miss", 32'(h), 32'd0);

        // R5: exact timeout with ticks every cycle.
        flush();
        ins(6'd7, 16'h0707, 1);
        for (int k = 0; k < TO; k++) begin
            look(6'd7, 1, "R5", h, d);
            chk("R5 literal hit before limit", 32'(h), 32'd1);
        end
        look(6'd7, 1, "R5", h, d);
        chk("R5 literal miss at limit", 32'(h), 32'd0);
        // R5: no ageing without ticks.
        ins(6'd9, 16'h0909, 0);
        for (int k = 0; k < 3 * TO; k++) look(6'd9, 0, "R5 no tick", h, d);
        chk("R5 literal held without tick", 32'(h), 32'd1);

        // R7: re-insert resets age.
        flush();
        ins(6'd8, 16'h0808, 1);
        for (int k = 0; k < TO - 2; k++) look(6'd8, 1, "R7", h, d);
        ins(6'd8, 16'h0880, 1);
        for (int k = 0; k < TO - 1; k++) look(6'd8, 1, "R7", h, d);
        chk("R7 literal age reset", 32'(h), 32'd1);

        // R1/R6: fill with distinct ages, then replace the oldest.
        flush();
        for (int k = 0; k < N; k++) ins(TW'(10 + k), DW'(16'h100 + k), 1);
        for (int k = 0; k < N; k++) begin
            look(TW'(10 + k), 0, "R1", h, d);
            chk("R1 literal all held", 32'(h), 32'd1);
        end
        ins(6'd30, 16'h3030, 1);
        look(6'd10, 0, "R6", h, d);
        chk("R6 literal oldest replaced", 32'(h), 32'd0);
        look(6'd11, 0, "R6", h, d);
        chk("R6 literal next kept", 32'(h), 32'd1);

        // R6: equal ages, lowest index replaced.
        flush();
        for (int k = 0; k < N; k++) ins(TW'(40 + k), DW'(k), 0);
        ins(6'd60, 16'h6060, 0);
        look(6'd40, 0, "R6 tie", h, d);
        chk("R6 literal tie lowest", 32'(h), 32'd0);
        look(6'd41, 0, "R6 tie", h, d);
        chk("R6 literal tie kept", 32'(h), 32'd1);

        // R10: flush clears everything, and wins over an insert.
        step(1, 1, 6'd41, 16'hBEEF, 0, 0, '0, 0, '0, 1, 0, "R10", h, d);
        for (int k = 0; k < N; k++) look(TW'(40 + k), 0, "R10", h, d);
        look(6'd60, 0, "R10", h, d);
        chk("R10 literal empty", 32'(h), 32'd0);

        // Mixed sweep over a small tag set (R1..R12 against the model).
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1] | r[2], TW'(r[7:4] % 12), DW'($urandom),
                 r[8] | r[9], r[10] | r[11], TW'(r[15:12] % 12),
                 r[16] & r[17] & r[18], TW'(r[23:20] % 12),
                 (r[31:24] == 8'd0), r[19] | r[3], "sweep", h, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule